// File: doc/BRIEF.md
# Masked key-match input router

This block steers 32-bit event packets toward one of eight outgoing physical links. Each arriving packet carries a key, an optional 32-bit payload and a flag that says whether the payload is present. The key is compared against a table of sixteen programmable entries, split into two pipes of eight. Entry n of pipe p sits at table index p*8+n. An entry hits when the incoming key ANDed with the entry mask equals the entry key. When several entries hit, the one with the lowest table index decides the route.

The chosen route number (0 to 7) is turned into a one-hot link select over sixteen link positions. Only the odd positions are used: route 0 drives link 15, route 1 drives link 13, and so on down to route 7 on link 1. A packet that hits no entry is discarded and counted. Packets enter and leave over valid/ready streams, with a single output register between them. A write port loads keys, masks and routes. A combinational read port returns table contents and three saturating counters: accepted inputs, delivered outputs and drops.

Top module: `key_route_engine`

## Requirements
- R1: After reset, out_valid is 0, all counters read 0, every key reads all-ones, every mask reads 0 and every route reads 0, so no entry hits and out_link is 0.
- R2: A packet accepted with in_valid and in_ready high appears on out_key, out_payload and out_has_payload one cycle later with out_valid high, if at least one entry has (in_key & mask) == key.
- R3: When several entries hit, the route of the entry with the lowest table index p*8+n is used.
- R4: While out_valid is high, out_link has exactly one bit set, bit 15-2*route. Even bit positions are never set. While out_valid is low, out_link is 0.
- R5: An accepted packet that hits no entry produces no output, and the drop counter (read address 66) increments by one.
- R6: The input counter (read address 67) increments once for every accepted packet.
- R7: The output counter (read address 64) increments once for every cycle with out_valid and out_ready both high.
- R8: Each counter is CNT_W bits wide, stops at all-ones and never wraps.
- R9: A table write takes effect at the clock edge that ends its cycle. A packet accepted in that same cycle is resolved with the previous table contents; the next accepted packet uses the new contents.
- R10: While out_valid is high and out_ready is low, in_ready is low and out_key, out_payload and out_link hold their values. Otherwise in_ready is high.
- R11: Addresses 16+i, 32+i and 48+i hold the key, mask and route of entry i. A route keeps only the low 3 bits of the write data and reads back zero-extended. Counters read zero-extended. Every other read address returns 0. Writes to any address outside 16..63 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input packet can be taken |
| in_key | input | 32 | Input packet key |
| in_payload | input | 32 | Input packet payload |
| in_has_payload | input | 1 | Payload present flag |
| out_valid | output | 1 | Routed packet valid |
| out_ready | input | 1 | Downstream takes the routed packet |
| out_key | output | 32 | Routed packet key |
| out_payload | output | 32 | Routed packet payload |
| out_has_payload | output | 1 | Routed payload present flag |
| out_link | output | 16 | One-hot physical link select (odd bits only) |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 8 | Register read address |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
A corrupted table entry or a broken priority chain shows up on out_link one cycle after the affected packet is accepted. It can also show up as a drop-counter read that differs from the model on the very next cycle. A wrong output-register state appears at once as a mismatch on out_valid or in_ready, or as payload data that shifts while backpressure is applied. Counter faults, wrap-around included, appear on the read port the cycle after the event that should have moved the counter. A write applied one cycle early or late shows as a misrouted packet when that packet is accepted in the same cycle as the write.

// File: rtl/krt_pkg.sv
package krt_pkg;

    localparam int KEY_W            = 32;
    localparam int DATA_W           = 32;
    localparam int ADDR_W           = 8;
    localparam int N_PIPES          = 2;
    localparam int ENTRIES_PER_PIPE = 8;
    localparam int N_ENTRIES        = N_PIPES * ENTRIES_PER_PIPE;
    localparam int IDX_W            = $clog2(N_ENTRIES);
    localparam int N_ROUTES         = 8;
    localparam int ROUTE_W          = $clog2(N_ROUTES);
    localparam int N_LINKS          = 2 * N_ROUTES;

    localparam logic [ADDR_W-1:0] KEY_BASE      = 8'd16;
    localparam logic [ADDR_W-1:0] MASK_BASE     = 8'd32;
    localparam logic [ADDR_W-1:0] ROUTE_BASE    = 8'd48;
    localparam logic [ADDR_W-1:0] CNT_OUT_ADDR  = 8'd64;
    localparam logic [ADDR_W-1:0] CNT_DROP_ADDR = 8'd66;
    localparam logic [ADDR_W-1:0] CNT_IN_ADDR   = 8'd67;

    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [ROUTE_W-1:0] route_t;
    typedef logic [N_LINKS-1:0] link_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        key_t   key;
        key_t   mask;
        route_t route;
    } entry_t;

    typedef struct packed {
        key_t              key;
        logic [DATA_W-1:0] payload;
        logic              has_payload;
    } pkt_t;

    typedef struct packed {
        logic   hit;
        route_t route;
    } match_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_KEY,
        RK_MASK,
        RK_ROUTE,
        RK_CNT_OUT,
        RK_CNT_DROP,
        RK_CNT_IN
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        idx_t      idx;
    } reg_sel_t;

    // Table bases are multiples of the table size, so the upper address
    // bits alone pick the field and the low bits pick the entry.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.idx  = a[IDX_W-1:0];
        s.kind = RK_NONE;
        if (a[ADDR_W-1:IDX_W] == KEY_BASE[ADDR_W-1:IDX_W])
            s.kind = RK_KEY;
        else if (a[ADDR_W-1:IDX_W] == MASK_BASE[ADDR_W-1:IDX_W])
            s.kind = RK_MASK;
        else if (a[ADDR_W-1:IDX_W] == ROUTE_BASE[ADDR_W-1:IDX_W])
            s.kind = RK_ROUTE;
        else if (a == CNT_OUT_ADDR)
            s.kind = RK_CNT_OUT;
        else if (a == CNT_DROP_ADDR)
            s.kind = RK_CNT_DROP;
        else if (a == CNT_IN_ADDR)
            s.kind = RK_CNT_IN;
        return s;
    endfunction

    function automatic logic entry_hits(input key_t k, input entry_t e);
        return (k & e.mask) == e.key;
    endfunction

    // Route r drives the odd link 2*(N_ROUTES-1-r)+1, highest link first.
    function automatic link_t route_to_link(input route_t r);
        link_t l;
        l = '0;
        l[N_LINKS - 1 - 2 * int'(r)] = 1'b1;
        return l;
    endfunction

endpackage

// File: rtl/krt_entry_table.sv
module krt_entry_table
    import krt_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [ADDR_W-1:0]           raddr,
    output entry_t [N_ENTRIES-1:0]      entries,
    output logic [DATA_W-1:0]           rdata
);

    reg_sel_t wsel;
    reg_sel_t rsel;

    assign wsel = decode_addr(waddr);
    assign rsel = decode_addr(raddr);

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
            entry_t entry_q;
            logic   sel;

            assign sel = wr_en && (wsel.idx == idx_t'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    entry_q.key   <= '1;
                    entry_q.mask  <= '0;
                    entry_q.route <= '0;
                end else if (sel) begin
                    case (wsel.kind)
                        RK_KEY:   entry_q.key   <= wdata[KEY_W-1:0];
                        RK_MASK:  entry_q.mask  <= wdata[KEY_W-1:0];
                        RK_ROUTE: entry_q.route <= wdata[ROUTE_W-1:0];
                        default:  ;
                    endcase
                end
            end

            assign entries[g] = entry_q;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (rsel.kind)
            RK_KEY:   rdata = DATA_W'(entries[rsel.idx].key);
            RK_MASK:  rdata = DATA_W'(entries[rsel.idx].mask);
            RK_ROUTE: rdata = DATA_W'(entries[rsel.idx].route);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/krt_match.sv
module krt_match
    import krt_pkg::*;
(
    input  key_t                   key,
    input  entry_t [N_ENTRIES-1:0] entries,
    output match_t                 result
);

    // Scan from the top so the lowest hitting index is written last.
    always_comb begin
        result = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (entry_hits(key, entries[i])) begin
                result.hit   = 1'b1;
                result.route = entries[i].route;
            end
        end
    end

endmodule

// File: rtl/krt_sat_counter.sv
module krt_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && (count != '1))
            count <= count + 1'b1;
    end

endmodule

// File: rtl/key_route_engine.sv
module key_route_engine
    import krt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [KEY_W-1:0]    in_key,
    input  logic [DATA_W-1:0]   in_payload,
    input  logic                in_has_payload,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [KEY_W-1:0]    out_key,
    output logic [DATA_W-1:0]   out_payload,
    output logic                out_has_payload,
    output logic [N_LINKS-1:0]  out_link,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_waddr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]   cfg_raddr,
    output logic [DATA_W-1:0]   cfg_rdata
);

    localparam int N_CNT    = 3;
    localparam int CI_OUT   = 0;
    localparam int CI_DROP  = 1;
    localparam int CI_IN    = 2;

    entry_t [N_ENTRIES-1:0] entries;
    logic [DATA_W-1:0]      tbl_rdata;
    match_t                 hit_info;
    pkt_t                   stage_q;
    link_t                  link_q;
    logic                   valid_q;
    logic                   accept;
    logic                   deliver;
    logic [N_CNT-1:0]       cnt_inc;
    logic [CNT_W-1:0]       cnt_val [N_CNT];
    logic [CNT_W-1:0]       cnt_out_w;
    logic [CNT_W-1:0]       cnt_drop_w;
    logic [CNT_W-1:0]       cnt_in_w;
    reg_sel_t               rsel;

    krt_entry_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .waddr   (cfg_waddr),
        .wdata   (cfg_wdata),
        .raddr   (cfg_raddr),
        .entries (entries),
        .rdata   (tbl_rdata)
    );

    krt_match u_match (
        .key     (in_key),
        .entries (entries),
        .result  (hit_info)
    );

    assign in_ready = !valid_q || out_ready;
    assign accept   = in_valid && in_ready;
    assign deliver  = valid_q && out_ready;

    // Single output register; the table seen at the accept edge decides.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            stage_q <= '0;
            link_q  <= '0;
        end else if (accept) begin
            valid_q <= hit_info.hit;
            if (hit_info.hit) begin
                stage_q.key         <= in_key;
                stage_q.payload     <= in_payload;
                stage_q.has_payload <= in_has_payload;
                link_q              <= route_to_link(hit_info.route);
            end
        end else if (deliver) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid       = valid_q;
    assign out_key         = stage_q.key;
    assign out_payload     = stage_q.payload;
    assign out_has_payload = stage_q.has_payload;
    assign out_link        = valid_q ? link_q : '0;

    assign cnt_inc[CI_OUT]  = deliver;
    assign cnt_inc[CI_DROP] = accept && !hit_info.hit;
    assign cnt_inc[CI_IN]   = accept;

    generate
        for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
            krt_sat_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (cnt_inc[c]),
                .count (cnt_val[c])
            );
        end
    endgenerate

    assign cnt_out_w  = cnt_val[CI_OUT];
    assign cnt_drop_w = cnt_val[CI_DROP];
    assign cnt_in_w   = cnt_val[CI_IN];

    assign rsel = decode_addr(cfg_raddr);

    always_comb begin
        case (rsel.kind)
            RK_CNT_OUT:  cfg_rdata = DATA_W'(cnt_out_w);
            RK_CNT_DROP: cfg_rdata = DATA_W'(cnt_drop_w);
            RK_CNT_IN:   cfg_rdata = DATA_W'(cnt_in_w);
            default:     cfg_rdata = tbl_rdata;
        endcase
    end

endmodule

// File: rtl/krt_checker.sv
module krt_checker
    import krt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [KEY_W-1:0]   out_key,
    input logic [DATA_W-1:0]  out_payload,
    input logic [N_LINKS-1:0] out_link,
    input logic [CNT_W-1:0]   cnt_out,
    input logic [CNT_W-1:0]   cnt_drop,
    input logic [CNT_W-1:0]   cnt_in
);

    localparam link_t EVEN_BITS = {N_ROUTES{2'b01}};

    a_r10_hold_output: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_key)
            && $stable(out_payload) && $stable(out_link));

    a_r10_block_input: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    a_r4_onehot_odd: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot(out_link) && ((out_link & EVEN_BITS) == '0));

    a_r1_quiet_link: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_link == '0);

    a_r6_in_count: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (cnt_in != '1)
            |=> cnt_in == $past(cnt_in) + 1'b1);

    a_r7_out_count: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && (cnt_out != '1)
            |=> cnt_out == $past(cnt_out) + 1'b1);

    a_r5_route_or_drop: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (cnt_drop != '1)
            |=> (cnt_drop == $past(cnt_drop) + 1'b1) != out_valid);

    a_r5_drop_only_on_accept: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> cnt_drop == $past(cnt_drop));

    a_r8_no_wrap_in: assert property (@(posedge clk) disable iff (rst)
        cnt_in == '1 |=> cnt_in == '1);

    a_r8_no_wrap_drop: assert property (@(posedge clk) disable iff (rst)
        cnt_drop == '1 |=> cnt_drop == '1);

    a_r8_no_wrap_out: assert property (@(posedge clk) disable iff (rst)
        cnt_out == '1 |=> cnt_out == '1);

endmodule

bind key_route_engine krt_checker #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_key     (out_key),
    .out_payload (out_payload),
    .out_link    (out_link),
    .cnt_out     (cnt_out_w),
    .cnt_drop    (cnt_drop_w),
    .cnt_in      (cnt_in_w)
);

// File: tb/key_route_engine_tb_top.sv
module key_route_engine_tb_top;

    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_key = '0;
    logic [31:0] in_payload = '0;
    logic        in_has_payload = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_key;
    logic [31:0] out_payload;
    logic        out_has_payload;
    logic [15:0] out_link;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;

    always #2 clk = ~clk;

    key_route_engine #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
        .in_payload(in_payload), .in_has_payload(in_has_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
        .out_payload(out_payload), .out_has_payload(out_has_payload),
        .out_link(out_link),
        .cfg_wr_en(cfg_wr_en), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata)
    );

    // Behavioural reference model
    logic [31:0] m_key   [16];
    logic [31:0] m_mask  [16];
    int          m_route [16];
    bit          m_ov;
    logic [31:0] m_okey, m_opay;
    bit          m_ohp;
    int          m_olink;
    int          m_cin, m_cout, m_cdrop;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    function automatic int ref_lookup(logic [31:0] k);
        for (int i = 0; i < 16; i++)
            if ((k & m_mask[i]) == m_key[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] ref_read(int a);
        if (a >= 16 && a < 32) return m_key[a-16];
        if (a >= 32 && a < 48) return m_mask[a-32];
        if (a >= 48 && a < 64) return 32'(m_route[a-48]);
        if (a == 64) return 32'(m_cout);
        if (a == 66) return 32'(m_cdrop);
        if (a == 67) return 32'(m_cin);
        return 32'd0;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock cycle, entered and left at a falling edge.
    task automatic cycle(string tag, bit iv, logic [31:0] k, logic [31:0] p, bit hp,
                         bit ordy, bit wen, logic [7:0] wa, logic [31:0] wd, logic [7:0] ra);
        bit acc, dlv;
        int h;
        in_valid = iv; in_key = k; in_payload = p; in_has_payload = hp;
        out_ready = ordy; cfg_wr_en = wen; cfg_waddr = wa; cfg_wdata = wd; cfg_raddr = ra;
        #1;
        check(tag, "out_valid", 32'(out_valid), 32'(m_ov));
        check(tag, "in_ready", 32'(in_ready), 32'(!m_ov || ordy));
        if (m_ov) begin
            check(tag, "out_key", out_key, m_okey);
            check(tag, "out_payload", out_payload, m_opay);
            check(tag, "out_has_payload", 32'(out_has_payload), 32'(m_ohp));
            check(tag, "out_link", 32'(out_link), 32'(1) << m_olink);
        end else begin
            check(tag, "out_link idle", 32'(out_link), 32'd0);
        end
        check(tag, "cfg_rdata", cfg_rdata, ref_read(int'(ra)));
        acc = iv && (!m_ov || ordy);
        dlv = m_ov && ordy;
        if (dlv && m_cout < CMAX) m_cout++;
        if (acc && m_cin < CMAX) m_cin++;
        if (acc) begin
            h = ref_lookup(k);
            if (h < 0) begin
                if (m_cdrop < CMAX) m_cdrop++;
                m_ov = 1'b0;
            end else begin
                m_ov = 1'b1; m_okey = k; m_opay = p; m_ohp = hp;
                m_olink = 15 - 2 * m_route[h];
            end
        end else if (dlv) begin
            m_ov = 1'b0;
        end
        if (wen) begin
            if (wa >= 16 && wa < 32) m_key[wa-16] = wd;
            else if (wa >= 32 && wa < 48) m_mask[wa-32] = wd;
            else if (wa >= 48 && wa < 64) m_route[wa-48] = int'(wd[2:0]);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(string tag, logic [7:0] ra);
        cycle(tag, 0, 32'd0, 32'd0, 0, 1, 0, 8'd0, 32'd0, ra);
    endtask

    task automatic send(string tag, logic [31:0] k, logic [31:0] p, logic [7:0] ra);
        cycle(tag, 1, k, p, 1, 1, 0, 8'd0, 32'd0, ra);
    endtask

    task automatic wr(string tag, logic [7:0] wa, logic [31:0] wd, logic [7:0] ra);
        cycle(tag, 0, 32'd0, 32'd0, 0, 1, 1, wa, wd, ra);
    endtask

    function automatic logic [31:0] pick_key(int sel);
        case (sel)
            0: return 32'h0000_0123;
            1: return 32'h0000_03AB;
            2: return 32'hA000_1234;
            3: return 32'h0000_0005;
            4: return 32'h0000_0777;
            5: return 32'h0000_01F5;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 16; i++) begin
            m_key[i] = '1; m_mask[i] = '0; m_route[i] = 0;
        end
        m_ov = 0; m_okey = 0; m_opay = 0; m_ohp = 0; m_olink = 0;
        m_cin = 0; m_cout = 0; m_cdrop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents of every address
        for (int a = 0; a < 80; a++) idle("R1", 8'(a));

        // R5: nothing hits before programming
        send("R5", 32'h0000_0000, 32'h11, 8'd66);
        send("R5", 32'hFFFF_FFFF, 32'h22, 8'd66);
        send("R5", 32'h1234_5678, 32'h33, 8'd66);
        idle("R5", 8'd66);
        idle("R6", 8'd67);

        // R11: programming and readback
        wr("R11", 8'd32, 32'h0000_0F00, 8'd0);
        wr("R11", 8'd16, 32'h0000_0100, 8'd0);
        wr("R11", 8'd48, 32'h0000_0000, 8'd0);
        wr("R11", 8'd35, 32'h0000_0100, 8'd0);
        wr("R11", 8'd19, 32'h0000_0100, 8'd0);
        wr("R11", 8'd51, 32'hFFFF_FFFD, 8'd51);
        wr("R11", 8'd42, 32'hF000_0000, 8'd0);
        wr("R11", 8'd26, 32'hA000_0000, 8'd0);
        wr("R11", 8'd58, 32'h0000_0007, 8'd0);
        wr("R11", 8'd47, 32'h0000_000F, 8'd0);
        wr("R11", 8'd31, 32'h0000_0005, 8'd0);
        wr("R11", 8'd63, 32'h0000_0002, 8'd0);
        wr("R11", 8'd66, 32'h0000_003F, 8'd66);
        wr("R11", 8'd70, 32'h0000_0001, 8'd70);
        for (int a = 0; a < 80; a++) idle("R11", 8'(a));

        // R3: 0x123 hits entries 0 and 3, 0x3AB only entry 3
        send("R2", 32'h0000_0123, 32'hAAAA_0001, 8'd0);
        idle("R3", 8'd0);
        send("R2", 32'h0000_03AB, 32'hAAAA_0002, 8'd0);
        idle("R3", 8'd0);

        // R4: routes 7 and 2
        send("R4", 32'hA000_1234, 32'hBBBB_0001, 8'd0);
        idle("R4", 8'd0);
        send("R4", 32'h0000_0005, 32'hBBBB_0002, 8'd0);
        idle("R4", 8'd0);
        idle("R6", 8'd67);
        idle("R7", 8'd64);

        // R9: write in the same cycle as the accept
        wr("R9", 8'd33, 32'h0000_0FFF, 8'd0);
        cycle("R9", 1, 32'h0000_0777, 32'h9, 1, 1, 1, 8'd17, 32'h0000_0777, 8'd66);
        idle("R9", 8'd66);
        send("R9", 32'h0000_0777, 32'h10, 8'd66);
        idle("R9", 8'd66);

        // R10: backpressure with back-to-back traffic
        cycle("R10", 1, 32'h0000_0123, 32'hC1, 0, 0, 0, 8'd0, 32'd0, 8'd64);
        cycle("R10", 1, 32'h0000_0005, 32'hC2, 1, 0, 0, 8'd0, 32'd0, 8'd64);
        cycle("R10", 1, 32'h0000_0005, 32'hC2, 1, 0, 0, 8'd0, 32'd0, 8'd64);
        cycle("R10", 1, 32'h0000_0005, 32'hC2, 1, 1, 0, 8'd0, 32'd0, 8'd64);
        cycle("R10", 1, 32'hA000_0000, 32'hC3, 0, 1, 0, 8'd0, 32'd0, 8'd64);
        cycle("R10", 0, 32'h0, 32'h0, 0, 0, 0, 8'd0, 32'd0, 8'd64);
        idle("R7", 8'd64);

        // Mixed traffic with occasional rewrites and varying readiness
        for (int n = 0; n < 1500; n++) begin
            bit wen;
            logic [7:0] wa;
            wen = ($urandom % 25) == 0;
            wa  = 8'(16 + ($urandom % 56));
            cycle("R2", ($urandom % 4) != 0, pick_key(int'($urandom % 8)), $urandom,
                  ($urandom % 2) == 1, ($urandom % 3) != 0, wen, wa,
                  (wa >= 32 && wa < 48) ? 32'hFFFF_F000 | $urandom : $urandom,
                  8'($urandom % 80));
        end

        // R8: counters saturated and held
        idle("R8", 8'd64);
        idle("R8", 8'd66);
        idle("R8", 8'd67);
        for (int n = 0; n < 20; n++) send("R8", 32'hFFFF_FFFE, 32'h0, 8'd66);
        idle("R8", 8'd67);
        check("R8", "cnt_in saturated", cfg_rdata, 32'(CMAX));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule